// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block turns a simple request stream into command-pin activity for a single-data-rate SDRAM whose banks are already open. Read requests become READ commands, one per clock if the requester keeps asking, and each READ may go to any bank. A write request may cut short read data that is still on its way back from the memory. Before the WRITE goes out, the block raises the data-mask output early enough to blank the read words that would otherwise collide with the controller's own write data, because the mask takes two clocks to act on the memory's output buffers.

The CAS latency (two or three clocks) and an optional one-clock bus-turnaround gap are set by configuration inputs. While a write waits for its mask lead, the request interface drops ready. When the write goes out, the block raises the controller's data-output enable and applies the write byte mask. A read-valid strobe marks the cycles in which read data is actually captured, so words blanked by the mask are not reported.

Top module: `rdwr_turn_sched`

## Requirements
- R1: After reset the command pins show NOP, the mask is 0, the output enable and read-valid are low and ready is high.
- R2: A read request accepted in cycle t shows in cycle t+1 as READ (cs_n=0, ras_n=1, cas_n=0, we_n=1), with the bank on the bank pins and the column in the low address bits. The mask stays 0. Reads can be accepted on back-to-back cycles.
- R3: Every cycle with no READ or WRITE shows NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1).
- R4: Read-valid pulses CL cycles after a READ (CL=2 when cfg_cl3=0, CL=3 when cfg_cl3=1). It does not pulse if the mask was high two cycles before that data cycle.
- R5: An accepted write makes the next cycle a NOP with every mask bit high. Ready stays low, and the mask stays all high, for every cycle the write waits.
- R6: A WRITE (cs_n=0, ras_n=1, cas_n=0, we_n=0) goes out only when the mask was all high in the previous cycle. One of two conditions must also hold: the mask has been all high for 2+gap cycles in a row, or at least CL+1+gap cycles have passed since the last READ.
- R7: The WRITE goes out in the first cycle that meets R6. With no reads in flight it comes two cycles after the request is accepted. When the write is accepted right after the last READ at cycle R, it goes out at R+3+gap.
- R8: The data-output enable is high exactly in WRITE cycles and never in a cycle where read-valid is high.
- R9: In the WRITE cycle the mask equals the request's byte mask. In the next idle cycle the mask returns to 0.
- R10: When read and write requests arrive together, the write is taken and no READ results. Read requests are ignored while ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cl3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| cfg_gap | input | 1 | 1 adds a one-cycle turnaround gap before a WRITE |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| req_bank | input | BANK_W | Target bank of the request |
| req_col | input | COL_W | Target column of the request |
| req_wmask | input | MASK_W | Byte mask for a write request |
| req_ready | output | 1 | High when a request can be taken |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_bank | output | BANK_W | Bank select |
| sd_addr | output | ADDR_W | Address pins, column in the low bits |
| sd_dqm | output | MASK_W | Data mask |
| dq_oe | output | 1 | Controller data-bus output enable |
| rd_valid | output | 1 | Read data captured this cycle |

## Verification
The bench builds the block with its default widths: two bank bits, ten column bits, thirteen address bits and a two-bit mask. Both CAS latencies and both gap settings can be selected at run time through the configuration inputs. So one build covers every distance from the last READ to the WRITE, each case where the last read word is blanked or kept, the write-wins collision, and an idle write with no reads in flight.

// File: rtl/rts_pkg.sv
`timescale 1ns/1ps
package rts_pkg;
  // Command pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_READ  = 4'b0101,
    CMD_WRITE = 4'b0100
  } sd_cmd_e;

  // Width of the saturating age and hold counters
  localparam int CNT_W = 3;

  function automatic logic [1:0] cas_cycles(input logic cl3);
    return cl3 ? 2'd3 : 2'd2;
  endfunction

  // age : cycles from the last READ to the current output cycle
  // hold: consecutive all-high mask cycles ending in the current output cycle
  // True when a WRITE may take the next output cycle
  function automatic logic wr_lead_met(input logic [CNT_W-1:0] age,
                                       input logic [CNT_W-1:0] hold,
                                       input logic cl3, input logic gap);
    logic [CNT_W-1:0] age_need;
    logic [CNT_W-1:0] hold_need;
    age_need  = CNT_W'(cas_cycles(cl3)) + CNT_W'(gap);
    hold_need = CNT_W'(2) + CNT_W'(gap);
    return (age >= age_need) || (hold >= hold_need);
  endfunction
endpackage

// File: rtl/rts_wr_hold.sv
`timescale 1ns/1ps
module rts_wr_hold #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              release_wr,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [COL_W-1:0]  in_col,
  input  logic [MASK_W-1:0] in_mask,
  output logic              pend,
  output logic [BANK_W-1:0] p_bank,
  output logic [COL_W-1:0]  p_col,
  output logic [MASK_W-1:0] p_mask
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      p_bank <= '0;
      p_col  <= '0;
      p_mask <= '0;
    end else if (capture) begin
      pend   <= 1'b1;
      p_bank <= in_bank;
      p_col  <= in_col;
      p_mask <= in_mask;
    end else if (release_wr) begin
      pend   <= 1'b0;
    end
  end
endmodule

// File: rtl/rts_lead_track.sv
`timescale 1ns/1ps
module rts_lead_track
  import rts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nxt_is_read,
  input  logic nxt_dqm_full,
  input  logic cfg_cl3,
  input  logic cfg_gap,
  output logic lead_ok
);
  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] age_q;
  logic [CNT_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q  <= SAT;
      hold_q <= '0;
    end else begin
      if (nxt_is_read)     age_q <= '0;
      else if (age_q != SAT) age_q <= age_q + CNT_W'(1);
      if (!nxt_dqm_full)   hold_q <= '0;
      else if (hold_q != SAT) hold_q <= hold_q + CNT_W'(1);
    end
  end

  assign lead_ok = wr_lead_met(age_q, hold_q, cfg_cl3, cfg_gap);
endmodule

// File: rtl/rts_rd_track.sv
`timescale 1ns/1ps
module rts_rd_track
  import rts_pkg::*;
#(
  parameter int MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cur_is_read,
  input  logic cur_dqm_any,
  input  logic cfg_cl3,
  output logic rd_valid
);
  localparam int MASK_LAT = 2;

  // element k holds the state k+1 cycles ago
  logic [MAX_CL-1:0]   rd_sr;
  logic [MASK_LAT-1:0] dqm_sr;
  logic [1:0]          lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_sr  <= '0;
      dqm_sr <= '0;
    end else begin
      rd_sr  <= {rd_sr[MAX_CL-2:0], cur_is_read};
      dqm_sr <= {dqm_sr[MASK_LAT-2:0], cur_dqm_any};
    end
  end

  assign lat      = cas_cycles(cfg_cl3);
  assign rd_valid = rd_sr[lat - 2'd1] && !dqm_sr[MASK_LAT-1];
endmodule

// File: rtl/rdwr_turn_sched.sv
`timescale 1ns/1ps
module rdwr_turn_sched
  import rts_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int MASK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic              cfg_gap,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [COL_W-1:0]  req_col,
  input  logic [MASK_W-1:0] req_wmask,
  output logic              req_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_bank,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [MASK_W-1:0] sd_dqm,
  output logic              dq_oe,
  output logic              rd_valid
);
  localparam int MAX_CL = 3;

  // named events, also used by the checker
  logic accept_wr, accept_rd, issue_wr, lead_ok;
  logic is_read_out, is_write_out;

  logic              pend;
  logic [BANK_W-1:0] p_bank;
  logic [COL_W-1:0]  p_col;
  logic [MASK_W-1:0] p_mask;

  sd_cmd_e           cmd_q,  cmd_n;
  logic [BANK_W-1:0] bank_q, bank_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [MASK_W-1:0] dqm_q,  dqm_n;
  logic              oe_q,   oe_n;

  assign req_ready = !pend;
  assign accept_wr = !pend && wr_req;
  assign accept_rd = !pend && rd_req && !wr_req;
  assign issue_wr  = pend && lead_ok;

  rts_wr_hold #(.BANK_W(BANK_W), .COL_W(COL_W), .MASK_W(MASK_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .capture(accept_wr), .release_wr(issue_wr),
    .in_bank(req_bank), .in_col(req_col), .in_mask(req_wmask),
    .pend(pend), .p_bank(p_bank), .p_col(p_col), .p_mask(p_mask)
  );

  always_comb begin
    cmd_n  = CMD_NOP;
    bank_n = '0;
    addr_n = '0;
    dqm_n  = '0;
    oe_n   = 1'b0;
    if (issue_wr) begin
      cmd_n  = CMD_WRITE;
      bank_n = p_bank;
      addr_n = ADDR_W'(p_col);
      dqm_n  = p_mask;
      oe_n   = 1'b1;
    end else if (pend || accept_wr) begin
      dqm_n  = '1;
    end else if (accept_rd) begin
      cmd_n  = CMD_READ;
      bank_n = req_bank;
      addr_n = ADDR_W'(req_col);
    end
  end

  rts_lead_track u_lead (
    .clk(clk), .rst_n(rst_n),
    .nxt_is_read(cmd_n == CMD_READ), .nxt_dqm_full(&dqm_n),
    .cfg_cl3(cfg_cl3), .cfg_gap(cfg_gap), .lead_ok(lead_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      dqm_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      cmd_q  <= cmd_n;
      bank_q <= bank_n;
      addr_q <= addr_n;
      dqm_q  <= dqm_n;
      oe_q   <= oe_n;
    end
  end

  assign is_read_out  = (cmd_q == CMD_READ);
  assign is_write_out = (cmd_q == CMD_WRITE);

  rts_rd_track #(.MAX_CL(MAX_CL)) u_rd (
    .clk(clk), .rst_n(rst_n), .cur_is_read(is_read_out),
    .cur_dqm_any(|dqm_q), .cfg_cl3(cfg_cl3), .rd_valid(rd_valid)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_bank = bank_q;
  assign sd_addr = addr_q;
  assign sd_dqm  = dqm_q;
  assign dq_oe   = oe_q;
endmodule

// File: rtl/rts_checker.sv
`timescale 1ns/1ps
module rts_checker #(
  parameter int MASK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              is_read_out,
  input logic              is_write_out,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic              req_ready,
  input logic [MASK_W-1:0] sd_dqm
);
  AST_WR_AFTER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    is_write_out |-> $past(&sd_dqm)); // R6
  AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> is_write_out); // R8
  AST_OE_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !rd_valid); // R8
  AST_READ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    is_read_out |-> (sd_dqm == '0)); // R2
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(is_read_out, 2) || $past(is_read_out, 3))); // R4
  AST_WAIT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> (&sd_dqm)); // R5
  AST_WAIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> !is_read_out); // R10
endmodule

bind rdwr_turn_sched rts_checker #(.MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .is_read_out(is_read_out),
  .is_write_out(is_write_out), .dq_oe(dq_oe), .rd_valid(rd_valid),
  .req_ready(req_ready), .sd_dqm(sd_dqm)
);

// File: tb/rdwr_turn_sched_tb.sv
`timescale 1ns/1ps
module rdwr_turn_sched_tb;
  localparam int BANK_W = 2, COL_W = 10, ADDR_W = 13, MASK_W = 2;
  localparam logic [3:0] C_NOP = 4'b0111, C_RD = 4'b0101, C_WR = 4'b0100;
  // {cl3, gap, reads[3:0], read-to-write distance[3:0], valid words[3:0]}
  localparam int NVEC = 6;
  localparam logic [13:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 4'd1, 4'd3, 4'd1},
    {1'b0, 1'b1, 4'd3, 4'd4, 4'd3},
    {1'b1, 1'b0, 4'd1, 4'd3, 4'd0},
    {1'b1, 1'b0, 4'd4, 4'd3, 4'd3},
    {1'b1, 1'b1, 4'd2, 4'd4, 4'd1},
    {1'b0, 1'b0, 4'd5, 4'd3, 4'd5}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_cl3 = 1'b0, cfg_gap = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic [MASK_W-1:0] req_wmask = '0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, dq_oe, rd_valid;
  logic [BANK_W-1:0] sd_bank;
  logic [ADDR_W-1:0] sd_addr;
  logic [MASK_W-1:0] sd_dqm;

  rdwr_turn_sched #(.BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_gap(cfg_gap),
    .rd_req(rd_req), .wr_req(wr_req), .req_bank(req_bank), .req_col(req_col),
    .req_wmask(req_wmask), .req_ready(req_ready), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_bank(sd_bank), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .dq_oe(dq_oe),
    .rd_valid(rd_valid)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor, sampled on the falling edge
  int last_rd, first_rd, wr_cyc, n_valid, first_valid, n_reads, ready_low;
  int oe_bad = 0, lead_bad = 0, cmd_bad = 0;
  logic [3:0] mcmd;
  logic [MASK_W-1:0] prev_dqm = '0, wr_dqm, post_dqm;
  logic [ADDR_W-1:0] rd_addr;
  logic [BANK_W-1:0] rd_bank;
  bit after_wr = 0;

  task automatic clear_mon();
    last_rd = -1; first_rd = -1; wr_cyc = -1; n_valid = 0; first_valid = -1;
    n_reads = 0; ready_low = 0;
  endtask

  always @(negedge clk) if (rst_n) begin
    mcmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (after_wr) begin post_dqm = sd_dqm; after_wr = 0; end
    if (mcmd == C_RD) begin
      last_rd = cyc; n_reads++;
      if (first_rd < 0) first_rd = cyc;
      rd_addr = sd_addr; rd_bank = sd_bank;
    end
    if (mcmd == C_WR) begin
      wr_cyc = cyc; wr_dqm = sd_dqm; after_wr = 1;
      if (prev_dqm != '1) lead_bad++;
    end
    if (mcmd != C_RD && mcmd != C_WR && mcmd != C_NOP) cmd_bad++;
    if (rd_valid) begin n_valid++; if (first_valid < 0) first_valid = cyc; end
    if (dq_oe != (mcmd == C_WR)) oe_bad++;
    if (dq_oe && rd_valid) oe_bad++;
    if (!req_ready) ready_low++;
    prev_dqm = sd_dqm;
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int k;
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R3: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1 R3 nop after reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
    chk(sd_dqm == '0, "R1 dqm", sd_dqm, 0);
    chk(dq_oe == 1'b0, "R1 oe", dq_oe, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);

    // vector table: read stream truncated by a write
    for (int v = 0; v < NVEC; v++) begin
      cfg_cl3 = VECS[v][13]; cfg_gap = VECS[v][12];
      repeat (6) @(negedge clk);
      clear_mon();
      for (int i = 0; i < int'(VECS[v][11:8]); i++) begin
        rd_req = 1'b1; req_bank = BANK_W'(i); req_col = COL_W'(v * 16 + i);
        @(negedge clk);
      end
      rd_req = 1'b0; wr_req = 1'b1; req_wmask = 2'b10;
      @(negedge clk);
      wr_req = 1'b0;
      repeat (10) @(negedge clk);
      chk(wr_cyc - last_rd == int'(VECS[v][7:4]), "R7 R6 read-to-write distance",
          wr_cyc - last_rd, int'(VECS[v][7:4]));
      chk(n_valid == int'(VECS[v][3:0]), "R4 captured words", n_valid, int'(VECS[v][3:0]));
      chk(ready_low == int'(VECS[v][7:4]) - 1, "R5 ready low cycles",
          ready_low, int'(VECS[v][7:4]) - 1);
      chk(n_reads == int'(VECS[v][11:8]), "R2 back-to-back reads", n_reads, int'(VECS[v][11:8]));
    end

    // R2 / R4: single read, fields and CL3 latency
    cfg_cl3 = 1'b1; cfg_gap = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon(); k = cyc;
    rd_req = 1'b1; req_bank = 2'd2; req_col = 10'h155;
    @(negedge clk); rd_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(first_rd == k + 1, "R2 read cycle", first_rd, k + 1);
    chk(rd_addr == ADDR_W'(10'h155), "R2 column on address", rd_addr, 'h155);
    chk(rd_bank == 2'd2, "R2 bank", rd_bank, 2);
    chk(first_valid == k + 4, "R4 CL3 valid cycle", first_valid, k + 4);

    // R4: CL2 latency
    cfg_cl3 = 1'b0;
    repeat (4) @(negedge clk);
    clear_mon(); k = cyc;
    rd_req = 1'b1; req_col = 10'h2a;
    @(negedge clk); rd_req = 1'b0;
    repeat (6) @(negedge clk);
    chk(first_valid == k + 3, "R4 CL2 valid cycle", first_valid, k + 3);

    // R7 / R9 / R5: idle write
    repeat (4) @(negedge clk);
    clear_mon(); k = cyc;
    wr_req = 1'b1; req_wmask = 2'b01; req_bank = 2'd1; req_col = 10'h3;
    @(negedge clk); wr_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(wr_cyc == k + 2, "R7 idle write latency", wr_cyc, k + 2);
    chk(wr_dqm == 2'b01, "R9 write mask", wr_dqm, 1);
    chk(post_dqm == 2'b00, "R9 mask released", post_dqm, 0);
    chk(ready_low == 1, "R5 idle wait", ready_low, 1);

    // R10: write wins, reads ignored while waiting
    repeat (4) @(negedge clk);
    clear_mon(); k = cyc;
    rd_req = 1'b1; wr_req = 1'b1; req_wmask = 2'b00;
    @(negedge clk); wr_req = 1'b0;
    @(negedge clk);
    @(negedge clk); rd_req = 1'b0;
    repeat (5) @(negedge clk);
    chk(wr_cyc == k + 2, "R10 write taken", wr_cyc, k + 2);
    chk(first_rd == k + 3, "R10 first read after write", first_rd, k + 3);
    chk(n_reads == 1, "R10 read count", n_reads, 1);

    // global monitors
    chk(oe_bad == 0, "R8 output enable", oe_bad, 0);
    chk(lead_bad == 0, "R6 mask before write", lead_bad, 0);
    chk(cmd_bad == 0, "R3 command encodings", cmd_bad, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule